// File: doc/BRIEF.md
# DMA Controller Register File and Interrupt Block

This block is the memory-mapped control and status front end of a multi-channel DMA controller. It holds five 32-bit registers for each channel (source address, destination address, linked-list pointer, control, configuration). It also holds a global configuration register and per-channel raw terminal-count and error flags. It drives one combined interrupt line. The channel count is a parameter: 8 by default, 2 in a reduced build. The transfer engine sits outside this block. It sees each channel's registers through flattened export ports, and it reports back through one-cycle completion and error pulses.

Software reaches the block through a plain single-cycle port with a word address (byte offset divided by four) inside a 4 KB window. A write is taken at the clock edge while `bus_sel` and `bus_wr` are high. Read data is combinational from the current state while `bus_sel` is high and `bus_wr` is low. The port has no back-pressure: every access completes in the cycle it is presented, so no valid/ready pair is needed. The interrupt masks are not separate registers. Bit 15 of each channel's configuration word enables that channel's terminal-count interrupt, and bit 14 enables its error interrupt.

Top module: `dma_regfile`

## Requirements
- R1: After reset, every register and flag reads zero (apart from the identification bytes), `irq` is low, `glb_en` is low and all exported channel views are zero.
- R2: Channel c (c below the channel count) has its registers at word address 0x40 + 8*c + w: w=0 source, w=1 destination, w=2 list pointer, w=3 control, w=4 configuration. Each reads back the last value written. Words w=5..7 read zero.
- R3: A write to a channel slot at or above the channel count changes nothing, and a read of that slot returns zero.
- R4: A pulse on `tc_pulse[i]` or `err_pulse[i]` sets raw flag bit i. The raw terminal-count flags read at word 5 and the raw error flags at word 6, with bit i for channel i.
- R5: Word 1 returns raw terminal-count flags AND the mask formed from configuration bit 15 of each channel. Word 3 returns raw error flags AND configuration bit 14. Word 0 returns the OR of the two.
- R6: `irq` is high in exactly the cycles in which some masked terminal-count or masked error bit is set.
- R7: A write to word 2 clears each raw terminal-count flag whose data bit is 1, and a write to word 4 does the same for error flags. Zero bits leave flags alone. A set pulse in the same cycle as a clear of that bit leaves the flag set.
- R8: Word 7 returns a bitmap whose bit i is configuration bit 0 of channel i.
- R9: Word 12 holds only the controller enable in bit 0. It is driven on `glb_en`. All other written bits, including the two endianness selects (bits 1 and 2), are discarded and read as zero.
- R10: Words 0x3F8..0x3FF each return one identification byte in bits 7:0: 0x80 (0x81 when the channel count is not 8), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of the two clear words and of every unmapped word return zero. Writes to unmapped words change no state.
- R12: The export ports carry channel i's registers in bits [32*i+31:32*i] of each flattened bus, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address (byte offset >> 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tc_pulse | input | NCH | Per-channel terminal-count event |
| err_pulse | input | NCH | Per-channel error event |
| irq | output | 1 | Combined interrupt |
| glb_en | output | 1 | Controller enable |
| ch_src_o | output | 32*NCH | Exported source addresses |
| ch_dst_o | output | 32*NCH | Exported destination addresses |
| ch_lli_o | output | 32*NCH | Exported list pointers |
| ch_ctrl_o | output | 32*NCH | Exported control words |
| ch_conf_o | output | 32*NCH | Exported configuration words |

## Verification
The assertions take the engine's event pulses and the bus inputs to be known (not X) at every clock edge once reset is released. They also assume that a clear and a set of the same flag may coincide. The stimulus changes inputs only on falling edges and holds every pulse for exactly one cycle. It deliberately lines a clear up with a set pulse to exercise the priority rule. A second, two-channel instance shares the same bus so that the out-of-range slots and the alternate identification byte are exercised with legal inputs.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int WORD_W       = 32;
  localparam int MAX_CH       = 8;
  localparam int CH_REGS      = 5;
  localparam int TC_MASK_BIT  = 15;
  localparam int ERR_MASK_BIT = 14;
  localparam int CH_EN_BIT    = 0;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] lli;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] conf;
  } chan_regs_t;

  typedef enum logic [3:0] {
    G_STAT    = 4'd0,
    G_TCSTAT  = 4'd1,
    G_TCCLR   = 4'd2,
    G_ERRSTAT = 4'd3,
    G_ERRCLR  = 4'd4,
    G_RAWTC   = 4'd5,
    G_RAWERR  = 4'd6,
    G_ENCH    = 4'd7,
    G_CONF    = 4'd12
  } glb_idx_e;

  typedef enum logic [2:0] {
    W_SRC  = 3'd0,
    W_DST  = 3'd1,
    W_LLI  = 3'd2,
    W_CTRL = 3'd3,
    W_CONF = 3'd4
  } ch_word_e;

  function automatic logic [7:0] id_byte(input logic [2:0] k, input int nch);
    case (k)
      3'd0:    return (nch == MAX_CH) ? 8'h80 : 8'h81;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h0A;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec (
  input  logic [9:0] waddr,
  output logic       hit_glb,
  output logic [3:0] glb_idx,
  output logic       hit_ch,
  output logic [2:0] ch_idx,
  output logic [2:0] ch_word,
  output logic       hit_id,
  output logic [2:0] id_idx
);
  always_comb begin
    hit_glb = (waddr[9:4] == 6'd0);
    glb_idx = waddr[3:0];
    hit_ch  = (waddr[9:6] == 4'd1);
    ch_idx  = waddr[5:3];
    ch_word = waddr[2:0];
    hit_id  = (waddr[9:3] == 7'h7F);
    id_idx  = waddr[2:0];
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        word,
  input  logic [WORD_W-1:0] wdata,
  output chan_regs_t        regs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (we) begin
      case (ch_word_e'(word))
        W_SRC:   regs.src  <= wdata;
        W_DST:   regs.dst  <= wdata;
        W_LLI:   regs.lli  <= wdata;
        W_CTRL:  regs.ctrl <= wdata;
        W_CONF:  regs.conf <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tc_set,
  input  logic [NCH-1:0] err_set,
  input  logic [NCH-1:0] tc_clr,
  input  logic [NCH-1:0] err_clr,
  input  logic [NCH-1:0] tc_mask,
  input  logic [NCH-1:0] err_mask,
  output logic [NCH-1:0] raw_tc,
  output logic [NCH-1:0] raw_err,
  output logic [NCH-1:0] msk_tc,
  output logic [NCH-1:0] msk_err,
  output logic           irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_tc[i]  <= 1'b0;
        raw_err[i] <= 1'b0;
      end else begin
        if (tc_set[i])       raw_tc[i] <= 1'b1;
        else if (tc_clr[i])  raw_tc[i] <= 1'b0;
        if (err_set[i])      raw_err[i] <= 1'b1;
        else if (err_clr[i]) raw_err[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    msk_tc  = raw_tc & tc_mask;
    msk_err = raw_err & err_mask;
    irq     = |{msk_tc, msk_err};
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [9:0]          bus_waddr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NCH-1:0]      tc_pulse,
  input  logic [NCH-1:0]      err_pulse,
  output logic                irq,
  output logic                glb_en,
  output logic [NCH*32-1:0]   ch_src_o,
  output logic [NCH*32-1:0]   ch_dst_o,
  output logic [NCH*32-1:0]   ch_lli_o,
  output logic [NCH*32-1:0]   ch_ctrl_o,
  output logic [NCH*32-1:0]   ch_conf_o
);
  localparam int PAD = WORD_W - NCH;

  logic       hit_glb, hit_ch, hit_id;
  logic [3:0] glb_idx;
  logic [2:0] ch_idx, ch_word, id_idx;

  dma_addr_dec u_dec (
    .waddr   (bus_waddr),
    .hit_glb (hit_glb),
    .glb_idx (glb_idx),
    .hit_ch  (hit_ch),
    .ch_idx  (ch_idx),
    .ch_word (ch_word),
    .hit_id  (hit_id),
    .id_idx  (id_idx)
  );

  logic wr_cyc, rd_cyc;
  assign wr_cyc = bus_sel & bus_wr;
  assign rd_cyc = bus_sel & ~bus_wr;

  chan_regs_t     regs [NCH];
  logic [NCH-1:0] tc_mask, err_mask, ch_en;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic we_c;
    assign we_c = wr_cyc & hit_ch & (ch_idx == 3'(c));

    dma_chan_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_c),
      .word  (ch_word),
      .wdata (bus_wdata),
      .regs  (regs[c])
    );

    assign tc_mask[c]  = regs[c].conf[TC_MASK_BIT];
    assign err_mask[c] = regs[c].conf[ERR_MASK_BIT];
    assign ch_en[c]    = regs[c].conf[CH_EN_BIT];

    assign ch_src_o [c*32 +: 32] = regs[c].src;
    assign ch_dst_o [c*32 +: 32] = regs[c].dst;
    assign ch_lli_o [c*32 +: 32] = regs[c].lli;
    assign ch_ctrl_o[c*32 +: 32] = regs[c].ctrl;
    assign ch_conf_o[c*32 +: 32] = regs[c].conf;
  end

  logic           tc_clr_wr, err_clr_wr;
  logic [NCH-1:0] tc_clr, err_clr;
  logic [NCH-1:0] raw_tc, raw_err, msk_tc, msk_err;

  assign tc_clr_wr  = wr_cyc & hit_glb & (glb_idx == G_TCCLR);
  assign err_clr_wr = wr_cyc & hit_glb & (glb_idx == G_ERRCLR);
  assign tc_clr     = tc_clr_wr  ? bus_wdata[NCH-1:0] : '0;
  assign err_clr    = err_clr_wr ? bus_wdata[NCH-1:0] : '0;

  dma_irq_flags #(.NCH(NCH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .tc_set   (tc_pulse),
    .err_set  (err_pulse),
    .tc_clr   (tc_clr),
    .err_clr  (err_clr),
    .tc_mask  (tc_mask),
    .err_mask (err_mask),
    .raw_tc   (raw_tc),
    .raw_err  (raw_err),
    .msk_tc   (msk_tc),
    .msk_err  (msk_err),
    .irq      (irq)
  );

  logic gcfg_en;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gcfg_en <= 1'b0;
    else if (wr_cyc && hit_glb && glb_idx == G_CONF) gcfg_en <= bus_wdata[0];
  end
  assign glb_en = gcfg_en;

  function automatic logic [31:0] widen(input logic [NCH-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  chan_regs_t sel_regs;
  logic       ch_valid;
  always_comb begin
    sel_regs = '0;
    ch_valid = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_idx == 3'(i)) begin
        sel_regs = regs[i];
        ch_valid = 1'b1;
      end
    end
  end

  logic [31:0] glb_rd, ch_rd;
  always_comb begin
    case (glb_idx)
      G_STAT:    glb_rd = widen(msk_tc | msk_err);
      G_TCSTAT:  glb_rd = widen(msk_tc);
      G_ERRSTAT: glb_rd = widen(msk_err);
      G_RAWTC:   glb_rd = widen(raw_tc);
      G_RAWERR:  glb_rd = widen(raw_err);
      G_ENCH:    glb_rd = widen(ch_en);
      G_CONF:    glb_rd = {31'd0, gcfg_en};
      default:   glb_rd = '0;
    endcase
  end

  always_comb begin
    case (ch_word_e'(ch_word))
      W_SRC:   ch_rd = sel_regs.src;
      W_DST:   ch_rd = sel_regs.dst;
      W_LLI:   ch_rd = sel_regs.lli;
      W_CTRL:  ch_rd = sel_regs.ctrl;
      W_CONF:  ch_rd = sel_regs.conf;
      default: ch_rd = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_cyc) begin
      if (hit_glb)                bus_rdata = glb_rd;
      else if (hit_ch && ch_valid) bus_rdata = ch_rd;
      else if (hit_id)            bus_rdata = {24'd0, id_byte(id_idx, NCH)};
    end
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NCH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [9:0]        bus_waddr,
  input logic [31:0]       bus_wdata,
  input logic [NCH-1:0]    tc_pulse,
  input logic [NCH-1:0]    err_pulse,
  input logic [NCH-1:0]    raw_tc,
  input logic [NCH-1:0]    raw_err,
  input logic              irq,
  input logic              glb_en,
  input logic [NCH*32-1:0] ch_conf_o
);
  logic oob_wr;
  assign oob_wr = bus_sel && bus_wr && (bus_waddr[9:6] == 4'd1) &&
                  (int'(bus_waddr[5:3]) >= NCH);

  assert_tc_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_pulse) |=> ((raw_tc & $past(tc_pulse)) == $past(tc_pulse)));

  assert_err_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> ((raw_err & $past(err_pulse)) == $past(err_pulse)));

  assert_tc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 10'd2 && tc_pulse == '0)
      |=> ((raw_tc & $past(bus_wdata[NCH-1:0])) == '0));

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 10'd4 && err_pulse == '0)
      |=> ((raw_err & $past(bus_wdata[NCH-1:0])) == '0));

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_tc == '0 && raw_err == '0) |-> !irq);

  assert_gcfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 10'd12) |=> (glb_en == $past(bus_wdata[0])));

  assert_oob_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oob_wr |=> $stable(ch_conf_o));
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_waddr (bus_waddr),
  .bus_wdata (bus_wdata),
  .tc_pulse  (tc_pulse),
  .err_pulse (err_pulse),
  .raw_tc    (raw_tc),
  .raw_err   (raw_err),
  .irq       (irq),
  .glb_en    (glb_en),
  .ch_conf_o (ch_conf_o)
);

// File: tb/tb_dma_regfile.sv
module tb_dma_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_s;
  logic [7:0]  tc_pulse = '0, err_pulse = '0;
  logic        irq, glb_en, irq_s, glb_en_s;
  logic [255:0] ch_src_o, ch_dst_o, ch_lli_o, ch_ctrl_o, ch_conf_o;
  logic [63:0]  s_src, s_dst, s_lli, s_ctrl, s_conf;

  int n_chk = 0, n_fail = 0;
  bit running = 0;

  always #5 clk = ~clk;

  dma_regfile #(.NCH(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tc_pulse(tc_pulse), .err_pulse(err_pulse), .irq(irq), .glb_en(glb_en),
    .ch_src_o(ch_src_o), .ch_dst_o(ch_dst_o), .ch_lli_o(ch_lli_o),
    .ch_ctrl_o(ch_ctrl_o), .ch_conf_o(ch_conf_o)
  );

  dma_regfile #(.NCH(2)) dut_small (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s),
    .tc_pulse(tc_pulse[1:0]), .err_pulse(err_pulse[1:0]), .irq(irq_s),
    .glb_en(glb_en_s), .ch_src_o(s_src), .ch_dst_o(s_dst), .ch_lli_o(s_lli),
    .ch_ctrl_o(s_ctrl), .ch_conf_o(s_conf)
  );

  // behavioural reference model of the 8-channel instance
  logic [31:0] m_reg [8][5];
  logic [7:0]  m_tc, m_err;
  logic        m_en;

  function automatic logic [7:0] m_tmask();
    logic [7:0] v;
    for (int c = 0; c < 8; c++) v[c] = m_reg[c][4][15];
    return v;
  endfunction
  function automatic logic [7:0] m_emask();
    logic [7:0] v;
    for (int c = 0; c < 8; c++) v[c] = m_reg[c][4][14];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) for (int w = 0; w < 5; w++) m_reg[c][w] = '0;
      m_tc = '0; m_err = '0; m_en = 1'b0;
    end else begin
      logic [7:0] ctc, cerr;
      ctc = '0; cerr = '0;
      if (bus_sel && bus_wr) begin
        if (bus_waddr >= 10'h40 && bus_waddr < 10'h80) begin
          if (int'(bus_waddr[2:0]) < 5)
            m_reg[int'(bus_waddr[5:3])][int'(bus_waddr[2:0])] = bus_wdata;
        end else if (bus_waddr == 10'd2)  ctc  = bus_wdata[7:0];
        else if (bus_waddr == 10'd4)      cerr = bus_wdata[7:0];
        else if (bus_waddr == 10'd12)     m_en = bus_wdata[0];
      end
      m_tc  = (m_tc & ~ctc) | tc_pulse;
      m_err = (m_err & ~cerr) | err_pulse;
    end
  end

  function automatic logic [31:0] m_read(input int wa);
    logic [7:0] ids [8];
    ids = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (wa < 16) begin
      case (wa)
        0:  return {24'd0, (m_tc & m_tmask()) | (m_err & m_emask())};
        1:  return {24'd0, m_tc & m_tmask()};
        3:  return {24'd0, m_err & m_emask()};
        5:  return {24'd0, m_tc};
        6:  return {24'd0, m_err};
        7: begin
          logic [7:0] e;
          for (int c = 0; c < 8; c++) e[c] = m_reg[c][4][0];
          return {24'd0, e};
        end
        12: return {31'd0, m_en};
        default: return '0;
      endcase
    end else if (wa >= 'h40 && wa < 'h80) begin
      if ((wa % 8) < 5) return m_reg[(wa / 8) % 8][wa % 8];
      return '0;
    end else if (wa >= 'h3F8) return {24'd0, ids[wa - 'h3F8]};
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every clock: interrupt, enable and exported views against the model
  always @(negedge clk) begin
    if (running) begin
      check("R6 irq", {31'd0, irq},
            {31'd0, |((m_tc & m_tmask()) | (m_err & m_emask()))});
      check("R9 glb_en", {31'd0, glb_en}, {31'd0, m_en});
      for (int c = 0; c < 8; c++) begin
        check("R12 src",  ch_src_o [c*32 +: 32], m_reg[c][0]);
        check("R12 dst",  ch_dst_o [c*32 +: 32], m_reg[c][1]);
        check("R12 lli",  ch_lli_o [c*32 +: 32], m_reg[c][2]);
        check("R12 ctrl", ch_ctrl_o[c*32 +: 32], m_reg[c][3]);
        check("R12 conf", ch_conf_o[c*32 +: 32], m_reg[c][4]);
      end
    end
  end

  task automatic wr(input int wa, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_waddr = 10'(wa); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input string req, input int wa);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_waddr = 10'(wa);
    #1 check(req, bus_rdata, m_read(wa));
  endtask

  task automatic rd_small(input string req, input int wa, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_waddr = 10'(wa);
    #1 check(req, rdata_s, exp);
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] e);
    @(negedge clk);
    tc_pulse = t; err_pulse = e;
    @(negedge clk);
    tc_pulse = '0; err_pulse = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    running = 1;
    // R1: reset state
    for (int w = 0; w < 16; w++) rd("R1 global after reset", w);
    rd("R1 channel after reset", 'h44);
    // R2: channel register map
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 5; w++) wr('h40 + 8*c + w, 32'hA000_0000 + 32'(c*16 + w));
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 8; w++) rd("R2 channel readback", 'h40 + 8*c + w);
    // configuration words for masks and enables
    wr('h44, 32'h0000_8001);
    wr('h4C, 32'h0000_4000);
    wr('h54, 32'h0000_C001);
    for (int c = 3; c < 8; c++) wr('h40 + 8*c + 4, 32'h0);
    rd("R8 enabled channels", 7);
    // R4, R5, R6: set terminal-count flags
    pulse(8'hFF, 8'h00);
    rd("R4 raw tc", 5);
    rd("R5 masked tc", 1);
    rd("R5 combined", 0);
    // R7: partial and full clear
    wr(2, 32'h0000_0001);
    rd("R7 tc partial clear", 5);
    wr(2, 32'hFFFF_FFFF);
    rd("R7 tc full clear", 5);
    // error flags
    pulse(8'h00, 8'h0A);
    rd("R4 raw err", 6);
    rd("R5 masked err", 3);
    rd("R5 combined err", 0);
    // R7: set wins over simultaneous clear
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_waddr = 10'd4; bus_wdata = 32'hFF; err_pulse = 8'h02;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; err_pulse = '0;
    rd("R7 set beats clear", 6);
    check("R7 set beats clear direct", {24'd0, m_err}, 32'h02);
    // R11: clear words and unmapped read zero; unmapped write ignored
    rd("R11 tc clear reads zero", 2);
    rd("R11 err clear reads zero", 4);
    rd("R11 unmapped 0x020", 8);
    rd("R11 unmapped 0x02C", 11);
    rd("R11 unmapped 0x040", 'h10);
    rd("R11 unmapped 0x800", 'h200);
    wr('h200, 32'hFFFF_FFFF);
    wr('h0B, 32'hFFFF_FFFF);
    rd("R11 state after unmapped write", 6);
    rd("R11 state after unmapped write", 7);
    rd("R11 ch0 after unmapped write", 'h40);
    // R9: global configuration
    wr(12, 32'hFFFF_FFFF);
    rd("R9 config keeps only bit0", 12);
    wr(12, 32'h0000_0006);
    rd("R9 endian bits dropped", 12);
    // R10: identification bytes
    for (int k = 0; k < 8; k++) rd("R10 id byte", 'h3F8 + k);
    // R3 and R10 on the two-channel build
    rd_small("R3 small ch1 src mapped", 'h48, 32'hA000_0010);
    rd_small("R3 small ch2 src reads zero", 'h50, 32'h0);
    wr('h54, 32'h0000_0001);
    rd_small("R3 small ch2 conf write ignored", 'h54, 32'h0);
    rd_small("R3 small enabled map", 7, 32'h1);
    rd_small("R10 small id byte 0", 'h3F8, 32'h81);
    rd_small("R10 small id byte 7", 'h3FF, 32'hB1);
    rd("R8 enabled after ch2 write", 7);
    @(negedge clk);
    bus_sel = 0;
    repeat (2) @(negedge clk);
    running = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule